// File: doc/BRIEF.md
# Byte-Serial Big-Endian Load/Store Unit

This unit moves a value of 1, 2, 4 or 8 bytes between a 64-bit register and a memory that transfers one byte per cycle. A request gives a start strobe, a direction, a size code, a signed/unsigned select, a byte address and, for stores, the register value. The unit checks the size and alignment first. It rejects a bad request without touching memory. A valid request is then carried out one byte per cycle in ascending address order, most significant byte first.

A load builds the result by shifting in each new byte. A signed load fills the upper bits from the top bit of the byte at the lowest address. An unsigned load fills them with zeros, which is the form used for instruction fetch (4 bytes, unsigned). A store sends the register's bytes so that the least significant byte goes to the highest address of the access. A one-cycle done pulse marks completion. A one-cycle fault pulse marks a rejected request.

Top module: `bytewise_lsu`

## Requirements
- R1: The size code gives 2^code bytes for codes 0 to 3. Codes 4 to 7 are rejected: fault pulses in the first cycle after the start edge, no memory write happens and done is not raised.
- R2: A request whose address is not a multiple of its byte count is rejected the same way: fault pulses in the first cycle after the start edge, with no memory access, and ld_result does not change.
- R3: A load of N bytes reads addresses addr to addr+N-1 in ascending order. The byte at the lowest address becomes the most significant byte of the value. Memory read data arrive one cycle after the address. done and the final ld_result appear in cycle N+2, where cycle 1 is the one after the start edge.
- R4: A signed load fills all bits above the loaded bytes with bit 7 of the byte at the lowest address. An unsigned load fills them with zeros.
- R5: A store of N bytes raises mem_we for exactly N consecutive cycles, with addresses ascending from addr. Address addr+N-1 receives bits 7:0 of the store data, and address addr receives the most significant stored byte.
- R6: A store raises done in cycle N+1 after the start edge, and a store leaves ld_result unchanged.
- R7: done is high for exactly one cycle per completed access.
- R8: While an access is in progress, req_start is ignored: it causes no extra memory write and no extra done.
- R9: After reset, done, fault and mem_we are low and ld_result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Starts an access when the unit is idle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | Byte count code, 2^code bytes |
| req_signed | input | 1 | Load sign-extends when 1 |
| req_addr | input | 64 | Byte address of the access |
| req_wdata | input | 64 | Register value to store |
| ld_result | output | 64 | Assembled load value |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle pulse for a rejected request |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after its address |

## Verification
The assertions check on every cycle that done never lasts two cycles and never coincides with a write or a fault. They also check that a fault follows a start and comes with no write, and that back-to-back write cycles step the address up by one. Byte order, sign filling, the completion latency for each size, an unchanged ld_result after a store or rejection, and the ignoring of a start during a busy access all depend on data values and memory contents. Only the bench's scenarios can show these, by comparing against its own memory model.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_TAIL = 2'd2
   } lsu_state_e;
endpackage

// File: rtl/lsu_req_check.sv
module lsu_req_check #(
   parameter int ADDR_W = 64,
   parameter int SIZE_W = 3,
   parameter int IDX_W  = 3
) (
   input  logic [SIZE_W-1:0] size_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ok_o,
   output logic [IDX_W-1:0]  last_o
);
   logic             size_ok;
   logic [IDX_W-1:0] span_m1;

   assign size_ok = (int'(size_i) <= IDX_W);

   always_comb begin
      for (int j = 0; j < IDX_W; j++) begin
         span_m1[j] = (j < int'(size_i));
      end
   end

   assign last_o = span_m1;
   assign ok_o   = size_ok && ((addr_i[IDX_W-1:0] & span_m1) == '0);
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
   import lsu_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              store_i,
   input  logic              signed_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              req_ok_i,
   input  logic [IDX_W-1:0]  last_i,
   output logic              take_o,
   output logic              xfer_o,
   output logic              is_store_o,
   output logic              is_signed_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [IDX_W-1:0]  last_o,
   output logic              cap_en_o,
   output logic              cap_first_o,
   output logic              done_o,
   output logic              fault_o
);
   lsu_state_e state;

   assign take_o = start_i && (state == ST_IDLE) && req_ok_i;
   assign xfer_o = (state == ST_XFER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         idx_o       <= '0;
         last_o      <= '0;
         base_o      <= '0;
         is_store_o  <= 1'b0;
         is_signed_o <= 1'b0;
         cap_en_o    <= 1'b0;
         cap_first_o <= 1'b0;
         done_o      <= 1'b0;
         fault_o     <= 1'b0;
      end else begin
         done_o      <= 1'b0;
         fault_o     <= 1'b0;
         cap_en_o    <= (state == ST_XFER) && !is_store_o;
         cap_first_o <= (state == ST_XFER) && (idx_o == '0);
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  if (req_ok_i) begin
                     base_o      <= addr_i;
                     idx_o       <= '0;
                     last_o      <= last_i;
                     is_store_o  <= store_i;
                     is_signed_o <= signed_i;
                     state       <= ST_XFER;
                  end else begin
                     fault_o <= 1'b1;
                  end
               end
            end
            ST_XFER: begin
               idx_o <= idx_o + 1'b1;
               if (idx_o == last_o) begin
                  if (is_store_o) begin
                     state  <= ST_IDLE;
                     done_o <= 1'b1;
                  end else begin
                     state <= ST_TAIL;
                  end
               end
            end
            ST_TAIL: begin
               state  <= ST_IDLE;
               done_o <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lsu_gather.sv
module lsu_gather #(
   parameter int DATA_W       = 64,
   parameter bit ALLOW_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en_i,
   input  logic              cap_first_i,
   input  logic              sign_en_i,
   input  logic [7:0]        rdata_i,
   output logic [DATA_W-1:0] acc_o
);
   logic fill;

   generate
      if (ALLOW_SIGNED) begin : g_sext
         assign fill = sign_en_i & rdata_i[7];
      end else begin : g_zext
         assign fill = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o <= '0;
      end else if (cap_en_i) begin
         if (cap_first_i) acc_o <= {{(DATA_W-8){fill}}, rdata_i};
         else             acc_o <= {acc_o[DATA_W-9:0], rdata_i};
      end
   end
endmodule

// File: rtl/lsu_scatter.sv
module lsu_scatter #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 3
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [IDX_W-1:0]  last_i,
   output logic [7:0]        byte_o
);
   localparam int LANES = DATA_W / 8;

   logic [7:0]       lane [LANES];
   logic [IDX_W-1:0] pick;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = data_i[8*g +: 8];
   end

   assign pick   = last_i - idx_i;
   assign byte_o = lane[pick];
endmodule

// File: rtl/bytewise_lsu.sv
module bytewise_lsu #(
   parameter int ADDR_W       = 64,
   parameter int DATA_W       = 64,
   parameter int SIZE_W       = 3,
   parameter bit ALLOW_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic              req_store,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_signed,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] ld_result,
   output logic              done,
   output logic              fault,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   input  logic [7:0]        mem_rdata
);
   localparam int MAX_BYTES = DATA_W / 8;
   localparam int IDX_W     = $clog2(MAX_BYTES);

   initial begin
      assert (DATA_W % 8 == 0 && MAX_BYTES >= 2 && (1 << IDX_W) == MAX_BYTES)
         else $error("DATA_W must be a power-of-two byte count of at least 2");
      assert ((1 << SIZE_W) > IDX_W)
         else $error("SIZE_W too narrow for the largest size code");
      assert (ADDR_W > IDX_W)
         else $error("ADDR_W too narrow");
   end

   logic              req_ok, take, xfer, is_store, is_signed;
   logic              cap_en, cap_first;
   logic [IDX_W-1:0]  last_req, last_q, idx;
   logic [ADDR_W-1:0] base;
   logic [DATA_W-1:0] wdata_q;

   lsu_req_check #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_check (
      .size_i (req_size),
      .addr_i (req_addr),
      .ok_o   (req_ok),
      .last_o (last_req)
   );

   lsu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (req_start),
      .store_i     (req_store),
      .signed_i    (req_signed),
      .addr_i      (req_addr),
      .req_ok_i    (req_ok),
      .last_i      (last_req),
      .take_o      (take),
      .xfer_o      (xfer),
      .is_store_o  (is_store),
      .is_signed_o (is_signed),
      .base_o      (base),
      .idx_o       (idx),
      .last_o      (last_q),
      .cap_en_o    (cap_en),
      .cap_first_o (cap_first),
      .done_o      (done),
      .fault_o     (fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    wdata_q <= '0;
      else if (take) wdata_q <= req_wdata;
   end

   lsu_scatter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_scatter (
      .data_i (wdata_q),
      .idx_i  (idx),
      .last_i (last_q),
      .byte_o (mem_wdata)
   );

   lsu_gather #(.DATA_W(DATA_W), .ALLOW_SIGNED(ALLOW_SIGNED)) u_gather (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_en_i    (cap_en),
      .cap_first_i (cap_first),
      .sign_en_i   (is_signed),
      .rdata_i     (mem_rdata),
      .acc_o       (ld_result)
   );

   assign mem_addr = base + ADDR_W'(idx);
   assign mem_we   = xfer && is_store;
endmodule

// File: rtl/lsu_sva.sv
module lsu_sva #(
   parameter int ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_start,
   input logic              done,
   input logic              fault,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_FAULT_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> $past(req_start)); // R1
   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!mem_we && !done)); // R2
   AST_WRITE_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R5
   AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_we); // R6
endmodule

bind bytewise_lsu lsu_sva #(.ADDR_W(ADDR_W)) u_lsu_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .done      (done),
   .fault     (fault),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/tb_bytewise_lsu.sv
module tb_bytewise_lsu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0, req_store = 1'b0, req_signed = 1'b0;
   logic [2:0]  req_size = '0;
   logic [63:0] req_addr = '0, req_wdata = '0;
   logic [63:0] ld_result, mem_addr;
   logic        done, fault, mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;

   logic [7:0]  mem     [256];
   logic [7:0]  ref_mem [256];
   int          n_chk = 0, n_bad = 0;
   int          we_cnt = 0, done_cnt = 0;

   always #10 clk = ~clk;

   bytewise_lsu dut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_store(req_store),
      .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
      .req_wdata(req_wdata), .ld_result(ld_result), .done(done), .fault(fault),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= pat(i);
         mem_rdata <= 8'h00;
      end else begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         mem_rdata <= mem[mem_addr[7:0]];
         if (mem_we) we_cnt <= we_cnt + 1;
         if (done)   done_cnt <= done_cnt + 1;
      end
   end

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_load(int a, int n, bit sgn);
      logic [63:0] v;
      v = (sgn && ref_mem[a][7]) ? '1 : '0;
      for (int i = 0; i < n; i++) v = {v[55:0], ref_mem[a + i]};
      return v;
   endfunction

   task automatic access(bit st, logic [2:0] sz, bit sgn, logic [63:0] a,
                         logic [63:0] wd, output int cyc, output bit gd,
                         output bit gf);
      @(negedge clk);
      req_start = 1'b1; req_store = st; req_size = sz; req_signed = sgn;
      req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_start = 1'b0;
      cyc = 1;
      while (!(done || fault) && cyc < 20) begin
         @(negedge clk);
         cyc++;
      end
      gd = done; gf = fault;
   endtask

   task automatic do_load(logic [2:0] sz, bit sgn, int a, string req);
      int cyc; bit gd, gf; int n;
      logic [63:0] exp;
      n = 1 << sz;
      exp = ref_load(a, n, sgn);
      access(1'b0, sz, sgn, 64'(a), '0, cyc, gd, gf);
      chk(gd && !gf && cyc == n + 2, req, 64'(cyc), 64'(n + 2));
      chk(ld_result == exp, req, ld_result, exp);
   endtask

   task automatic do_store(logic [2:0] sz, int a, logic [63:0] wd);
      int cyc; bit gd, gf; int n, w0;
      logic [63:0] res0;
      n = 1 << sz;
      w0 = we_cnt; res0 = ld_result;
      access(1'b1, sz, 1'b0, 64'(a), wd, cyc, gd, gf);
      chk(gd && !gf && cyc == n + 1, "R6 store latency", 64'(cyc), 64'(n + 1));
      chk(ld_result == res0, "R6 result kept", ld_result, res0);
      @(negedge clk);
      chk(!done, "R7 done pulse", 64'(done), 64'd0);
      chk(we_cnt - w0 == n, "R5 write count", 64'(we_cnt - w0), 64'(n));
      for (int i = 0; i < n; i++) ref_mem[a + n - 1 - i] = wd[8*i +: 8];
   endtask

   task automatic t_reset();
      chk(!done && !fault && !mem_we, "R9 reset ctrl",
          {61'd0, done, fault, mem_we}, 64'd0);
      chk(ld_result == 64'd0, "R9 reset result", ld_result, 64'd0);
   endtask

   task automatic t_loads();
      do_load(3'd0, 1'b0, 8, "R3 load 1");
      do_load(3'd1, 1'b0, 10, "R3 load 2");
      do_load(3'd2, 1'b0, 12, "R3 load 4");
      do_load(3'd3, 1'b0, 16, "R3 load 8");
      do_load(3'd0, 1'b1, 4, "R4 signed neg byte");
      do_load(3'd0, 1'b1, 0, "R4 signed pos byte");
      do_load(3'd1, 1'b0, 4, "R4 unsigned high bit");
   endtask

   task automatic t_stores();
      do_store(3'd3, 64, 64'h0123456789ABCDEF);
      do_load(3'd0, 1'b0, 71, "R5 lsb at top address");
      do_load(3'd0, 1'b0, 64, "R5 msb at base");
      do_load(3'd3, 1'b0, 64, "R5 store readback");
      do_store(3'd1, 82, 64'hFFFF_FFFF_FFFF_8001);
      do_load(3'd3, 1'b0, 80, "R5 neighbours kept");
      do_load(3'd1, 1'b1, 82, "R4 signed halfword");
      do_store(3'd2, 88, 64'h0000_0000_F000_0042);
      do_load(3'd2, 1'b1, 88, "R4 signed word");
   endtask

   task automatic t_reject();
      int cyc; bit gd, gf; int w0;
      logic [63:0] r0;
      r0 = ld_result; w0 = we_cnt;
      access(1'b0, 3'd3, 1'b0, 64'd68, '0, cyc, gd, gf);
      chk(gf && !gd && cyc == 1, "R2 misaligned load", 64'(cyc), 64'd1);
      chk(ld_result == r0, "R2 result kept", ld_result, r0);
      access(1'b1, 3'd1, 1'b0, 64'd97, 64'hAAAA, cyc, gd, gf);
      chk(gf && !gd && cyc == 1, "R2 misaligned store", 64'(cyc), 64'd1);
      chk(we_cnt == w0, "R2 no write", 64'(we_cnt), 64'(w0));
      do_load(3'd3, 1'b0, 96, "R2 memory kept");
      w0 = we_cnt;
      access(1'b1, 3'd5, 1'b0, 64'd0, 64'h55, cyc, gd, gf);
      chk(gf && !gd && cyc == 1, "R1 bad size", 64'(cyc), 64'd1);
      chk(we_cnt == w0, "R1 no write", 64'(we_cnt), 64'(w0));
   endtask

   task automatic t_busy();
      int w0, d0, cyc;
      w0 = we_cnt; d0 = done_cnt;
      @(negedge clk);
      req_start = 1'b1; req_store = 1'b1; req_size = 3'd3; req_signed = 1'b0;
      req_addr = 64'd128; req_wdata = 64'h1122334455667788;
      @(negedge clk);
      req_addr = 64'd160; req_wdata = 64'hDEADBEEFDEADBEEF;
      @(negedge clk);
      @(negedge clk);
      req_start = 1'b0;
      cyc = 0;
      while (!done && cyc < 20) begin @(negedge clk); cyc++; end
      @(negedge clk);
      @(negedge clk);
      chk(we_cnt - w0 == 8, "R8 one access only", 64'(we_cnt - w0), 64'd8);
      chk(done_cnt - d0 == 1, "R8 one done", 64'(done_cnt - d0), 64'd1);
      for (int i = 0; i < 8; i++) ref_mem[128 + 7 - i] = 8'((64'h1122334455667788 >> (8*i)) & 8'hFF);
      do_load(3'd3, 1'b0, 160, "R8 ignored target kept");
      do_load(3'd3, 1'b0, 128, "R8 accepted store");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) ref_mem[i] = pat(i);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_loads();
      t_stores();
      t_reject();
      t_busy();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule